// File: doc/BRIEF.md
# Tag-Capture Reservation Station

This block holds decoded instructions until their source operands are available and then dispatches them to one execution unit. Operands are fetched at issue time: a source that the register file already marks valid is copied into the entry as a value, and a source that is still being produced is stored as the index of the register that will deliver it, with its valid flag clear. A single result bus broadcasts a destination index with its value, and every occupied entry compares that index with its waiting tags in parallel. On a match, the entry takes the value and sets the flag.

An entry whose two flags are both set may be dispatched with its opcode, both operands and its destination index. At most one instruction is dispatched per cycle. Among the candidates the oldest wins. An age matrix keeps this correct after entries leave out of slot order. A mode input picks strict in-order dispatch, where only the oldest occupant is considered, or partially out-of-order dispatch, where the oldest ready occupant goes. A second mode input enables a bypass: an instruction that reaches an empty station with both operands already valid goes to the execution unit in the same cycle and is never stored.

Occupancy is tracked by a small state machine with three states. ST_EMPTY holds no entries. ST_PARTIAL holds between one and DEPTH-1 entries. ST_FULL holds DEPTH entries. Its transitions are ACCEPT (ST_EMPTY to ST_PARTIAL on a store), FILL (ST_PARTIAL to ST_FULL when the last slot is taken), RELIEVE (ST_FULL to ST_PARTIAL on a dispatch without a store) and DRAIN (ST_PARTIAL to ST_EMPTY when the last entry leaves). Issue is accepted in every state except ST_FULL, and bypass is possible only in ST_EMPTY.

Top module: `tagcap_station`

## Requirements
- R1: After reset the station is empty: `disp_valid` is 0 and `iss_ready` is 1.
- R2: An instruction issued with both operands valid, and not bypassed, appears on the dispatch port in the cycle after the issue edge with its opcode, operand values and destination. It leaves at the following edge.
- R3: A source issued with its ok flag low is held as the tag given on `iss_a_tag` or `iss_b_tag`. The entry does not dispatch until a broadcast carries that tag. In the cycle after that broadcast edge it dispatches with the broadcast value in that operand position.
- R4: Only entries whose two operand flags are both set are dispatched.
- R5: With `bypass_en` = 1, an issue that finds the station empty and has both operands valid drives the dispatch port in the same cycle and is not stored. An issue with a missing operand is stored as usual.
- R6: With bypass off, an issued instruction is never dispatched in its own issue cycle.
- R7: A broadcast in the same cycle as an issue whose missing source tag matches it is captured at issue, so the entry is ready in the next cycle.
- R8: With `in_order` = 0, when several entries are ready, the one issued earliest is dispatched first, whatever slot it occupies.
- R9: With `in_order` = 1, only the oldest occupant can dispatch. A younger ready entry waits behind it.
- R10: With DEPTH entries held, `iss_ready` is 0 and an issue attempt is ignored and stores nothing.
- R11: A broadcast whose index matches no waiting tag changes no entry.
- R12: At most one instruction is dispatched per cycle. Entries that become ready together leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Enables the direct path when the station is empty |
| in_order | input | 1 | 1: only the oldest entry may dispatch; 0: oldest ready entry |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_ready | output | 1 | Station can store an instruction this cycle |
| iss_op | input | 6 | Opcode |
| iss_a_ok | input | 1 | Register file marks source A valid |
| iss_a_val | input | 32 | Source A value (used when ok) |
| iss_a_tag | input | 5 | Source A register index (used when not ok) |
| iss_b_ok | input | 1 | Register file marks source B valid |
| iss_b_val | input | 32 | Source B value (used when ok) |
| iss_b_tag | input | 5 | Source B register index (used when not ok) |
| iss_rd | input | 5 | Destination register index |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_rd | input | 5 | Destination index of the broadcast result |
| bc_val | input | 32 | Broadcast result value |
| disp_valid | output | 1 | An instruction is dispatched this cycle |
| disp_op | output | 6 | Dispatched opcode |
| disp_a | output | 32 | Dispatched operand A |
| disp_b | output | 32 | Dispatched operand B |
| disp_rd | output | 5 | Dispatched destination index |

## Verification
A stored instruction is due on the dispatch port in the cycle after the edge that stores it. An entry completed by a broadcast is due in the cycle after the broadcast edge. A bypassed instruction is due in the cycle it is offered. Every dispatch leaves at the next edge. The bench drives inputs just after a rising edge and samples at the falling edge of the cycle where each result is due. It adds explicit checks for absence in the cycles before, such as the issue cycle itself and the cycles spent waiting on a tag. A scoreboard queue receives each expected dispatch in the order the age rules predict, and any dispatch that arrives with the queue empty is reported as a failure.

// File: rtl/tagcap_pkg.sv
package tagcap_pkg;

    localparam int unsigned TC_DW  = 32;
    localparam int unsigned TC_TW  = 5;
    localparam int unsigned TC_OPW = 6;

    // one station slot: each operand field holds a value, or a tag in its low bits while *_ok is 0
    typedef struct packed {
        logic [TC_OPW-1:0] op;
        logic              a_ok;
        logic [TC_DW-1:0]  a;
        logic              b_ok;
        logic [TC_DW-1:0]  b;
        logic [TC_TW-1:0]  rd;
    } tc_entry_t;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_PARTIAL,
        ST_FULL
    } tc_state_e;

    // issue-time operand resolution: {ok, value-or-tag}
    function automatic logic [TC_DW:0] tc_fetch(
        input logic              ok,
        input logic [TC_DW-1:0]  val,
        input logic [TC_TW-1:0]  tag,
        input logic              bv,
        input logic [TC_TW-1:0]  brd,
        input logic [TC_DW-1:0]  bval
    );
        if (ok)
            return {1'b1, val};
        else if (bv && (brd == tag))
            return {1'b1, bval};
        else
            return {1'b0, {(TC_DW-TC_TW){1'b0}}, tag};
    endfunction

endpackage

// File: rtl/tagcap_slot.sv
module tagcap_slot
    import tagcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             free_i,
    input  tc_entry_t        wr_ent,
    input  logic             bc_valid,
    input  logic [TC_TW-1:0] bc_rd,
    input  logic [TC_DW-1:0] bc_val,
    output logic             busy,
    output logic             ready,
    output tc_entry_t        ent
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ent  <= '0;
        end else if (alloc) begin
            busy <= 1'b1;
            ent  <= wr_ent;
        end else begin
            if (free_i)
                busy <= 1'b0;
            if (busy && bc_valid) begin
                if (!ent.a_ok && (ent.a[TC_TW-1:0] == bc_rd)) begin
                    ent.a    <= bc_val;
                    ent.a_ok <= 1'b1;
                end
                if (!ent.b_ok && (ent.b[TC_TW-1:0] == bc_rd)) begin
                    ent.b    <= bc_val;
                    ent.b_ok <= 1'b1;
                end
            end
        end
    end

    assign ready = busy && ent.a_ok && ent.b_ok;

endmodule

// File: rtl/tagcap_age.sv
module tagcap_age #(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            alloc_oh,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);

    // older[j][i] set: slot j was filled before slot i
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_oh[i]) begin
                    older[i] <= '0;
                    for (int j = 0; j < DEPTH; j++) begin
                        if (j != i)
                            older[j][i] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tagcap_pick.sv
module tagcap_pick #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0]            busy,
    input  logic [DEPTH-1:0]            ready,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    input  logic                        in_order,
    output logic [DEPTH-1:0]            grant
);

    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] win;

    assign cand = in_order ? busy : ready;

    always_comb begin
        win = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic beaten;
            beaten = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if ((j != i) && cand[j] && older[j][i])
                    beaten = 1'b1;
            end
            win[i] = cand[i] && !beaten;
        end
    end

    assign grant = win & ready;

endmodule

// File: rtl/tagcap_station.sv
module tagcap_station
    import tagcap_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_en,
    input  logic              in_order,
    input  logic              iss_valid,
    output logic              iss_ready,
    input  logic [TC_OPW-1:0] iss_op,
    input  logic              iss_a_ok,
    input  logic [TC_DW-1:0]  iss_a_val,
    input  logic [TC_TW-1:0]  iss_a_tag,
    input  logic              iss_b_ok,
    input  logic [TC_DW-1:0]  iss_b_val,
    input  logic [TC_TW-1:0]  iss_b_tag,
    input  logic [TC_TW-1:0]  iss_rd,
    input  logic              bc_valid,
    input  logic [TC_TW-1:0]  bc_rd,
    input  logic [TC_DW-1:0]  bc_val,
    output logic              disp_valid,
    output logic [TC_OPW-1:0] disp_op,
    output logic [TC_DW-1:0]  disp_a,
    output logic [TC_DW-1:0]  disp_b,
    output logic [TC_TW-1:0]  disp_rd
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    tc_state_e                  state_q, state_d;
    logic [CW-1:0]              cnt_q, cnt_d;
    logic                       station_empty;
    logic [TC_DW:0]             opa, opb;
    tc_entry_t                  new_ent, sel_ent;
    logic                       bypass_fire, store, station_disp;
    logic [DEPTH-1:0]           busy, rdy, grant, alloc_oh;
    logic [DEPTH-1:0][DEPTH-1:0] older;
    tc_entry_t                  ent_q [DEPTH];

    // issue-time operand fetch, including same-cycle broadcast capture
    assign opa = tc_fetch(iss_a_ok, iss_a_val, iss_a_tag, bc_valid, bc_rd, bc_val);
    assign opb = tc_fetch(iss_b_ok, iss_b_val, iss_b_tag, bc_valid, bc_rd, bc_val);

    always_comb begin
        new_ent.op   = iss_op;
        new_ent.a_ok = opa[TC_DW];
        new_ent.a    = opa[TC_DW-1:0];
        new_ent.b_ok = opb[TC_DW];
        new_ent.b    = opb[TC_DW-1:0];
        new_ent.rd   = iss_rd;
    end

    assign bypass_fire = bypass_en && station_empty && iss_valid && opa[TC_DW] && opb[TC_DW];
    assign store       = iss_valid && iss_ready && !bypass_fire;

    // lowest free slot takes the new instruction
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (store && !busy[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        tagcap_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_oh[g]),
            .free_i   (grant[g]),
            .wr_ent   (new_ent),
            .bc_valid (bc_valid),
            .bc_rd    (bc_rd),
            .bc_val   (bc_val),
            .busy     (busy[g]),
            .ready    (rdy[g]),
            .ent      (ent_q[g])
        );
    end

    tagcap_age #(.DEPTH(DEPTH)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (alloc_oh),
        .older    (older)
    );

    tagcap_pick #(.DEPTH(DEPTH)) u_pick (
        .busy     (busy),
        .ready    (rdy),
        .older    (older),
        .in_order (in_order),
        .grant    (grant)
    );

    assign station_disp = |grant;

    always_comb begin
        sel_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i])
                sel_ent = ent_q[i];
        end
    end

    // occupancy state machine
    assign cnt_d = cnt_q + CW'(store) - CW'(station_disp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (store)                         // ACCEPT
                    state_d = (cnt_d == CNT_FULL) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (cnt_d == '0)                   // DRAIN
                    state_d = ST_EMPTY;
                else if (cnt_d == CNT_FULL)        // FILL
                    state_d = ST_FULL;
            end
            ST_FULL: begin
                if (cnt_d != CNT_FULL)             // RELIEVE
                    state_d = (cnt_d == '0) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        iss_ready     = 1'b0;
        station_empty = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                iss_ready     = 1'b1;
                station_empty = 1'b1;
            end
            ST_PARTIAL: iss_ready = 1'b1;
            ST_FULL:    iss_ready = 1'b0;
            default:    iss_ready = 1'b0;
        endcase
    end

    assign disp_valid = bypass_fire || station_disp;
    assign disp_op    = bypass_fire ? new_ent.op : sel_ent.op;
    assign disp_a     = bypass_fire ? new_ent.a  : sel_ent.a;
    assign disp_b     = bypass_fire ? new_ent.b  : sel_ent.b;
    assign disp_rd    = bypass_fire ? new_ent.rd : sel_ent.rd;

endmodule

// File: rtl/tagcap_station_chk.sv
module tagcap_station_chk #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass_en,
    input logic             bypass_fire,
    input logic             iss_ready,
    input logic [DEPTH-1:0] busy,
    input logic [DEPTH-1:0] ready,
    input logic [DEPTH-1:0] grant,
    input logic [CW-1:0]    cnt
);

    a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r4_grant_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~ready) == '0));

    a_r5_bypass_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_fire |-> (busy == '0));

    a_r5_bypass_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_en |-> !bypass_fire);

    a_r10_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !iss_ready);

    a_r10_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) == $countones(busy)));

endmodule

bind tagcap_station tagcap_station_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bypass_en   (bypass_en),
    .bypass_fire (bypass_fire),
    .iss_ready   (iss_ready),
    .busy        (busy),
    .ready       (rdy),
    .grant       (grant),
    .cnt         (cnt_q)
);

// File: tb/test_tagcap_station.sv
module test_tagcap_station;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass_en = 1'b0, in_order = 1'b0;
    logic        iss_valid = 1'b0, iss_ready;
    logic [5:0]  iss_op = '0;
    logic        iss_a_ok = 1'b0, iss_b_ok = 1'b0;
    logic [31:0] iss_a_val = '0, iss_b_val = '0;
    logic [4:0]  iss_a_tag = '0, iss_b_tag = '0, iss_rd = '0;
    logic        bc_valid = 1'b0;
    logic [4:0]  bc_rd = '0;
    logic [31:0] bc_val = '0;
    logic        disp_valid;
    logic [5:0]  disp_op;
    logic [31:0] disp_a, disp_b;
    logic [4:0]  disp_rd;

    int nchk = 0, nfail = 0;
    bit done = 0;

    typedef struct {
        logic [5:0]  op;
        logic [31:0] a, b;
        logic [4:0]  rd;
        string       req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz

    tagcap_station i_tagcap_station (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .in_order(in_order),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_a_ok(iss_a_ok), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
        .iss_b_ok(iss_b_ok), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
        .iss_rd(iss_rd), .bc_valid(bc_valid), .bc_rd(bc_rd), .bc_val(bc_val),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_rd(disp_rd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic set_iss(input logic [5:0] op, input logic aok, input logic [31:0] av,
                           input logic [4:0] at, input logic bok, input logic [31:0] bv,
                           input logic [4:0] bt, input logic [4:0] rd);
        iss_valid = 1'b1; iss_op = op;
        iss_a_ok = aok; iss_a_val = av; iss_a_tag = at;
        iss_b_ok = bok; iss_b_val = bv; iss_b_tag = bt;
        iss_rd = rd;
    endtask

    task automatic clr_iss();
        iss_valid = 1'b0;
    endtask

    task automatic bc_on(input logic [4:0] rd, input logic [31:0] val);
        bc_valid = 1'b1; bc_rd = rd; bc_val = val;
    endtask

    task automatic bc_off();
        bc_valid = 1'b0;
    endtask

    // driver side of the scoreboard
    task automatic expect_disp(input logic [5:0] op, input logic [31:0] a,
                               input logic [31:0] b, input logic [4:0] rd, input string req);
        exp_t e;
        e.op = op; e.a = a; e.b = b; e.rd = rd; e.req = req;
        q.push_back(e);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && disp_valid) begin
            nchk++;
            if (q.size() == 0) begin
                nfail++;
                $display("FAIL R4: unexpected dispatch op %0h rd %0h, expected none", disp_op, disp_rd);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (disp_op !== e.op || disp_a !== e.a || disp_b !== e.b || disp_rd !== e.rd) begin
                    nfail++;
                    $display("FAIL %s: actual op %0h a %0h b %0h rd %0h expected op %0h a %0h b %0h rd %0h",
                             e.req, disp_op, disp_a, disp_b, disp_rd, e.op, e.a, e.b, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        at_neg();
        check("R1 disp_valid", 32'(disp_valid), 0);
        check("R1 iss_ready", 32'(iss_ready), 1);

        // R2 / R6: both operands ready, straightforward mode
        step();
        expect_disp(6'h01, 32'h11, 32'h22, 5'd1, "R2");
        set_iss(6'h01, 1, 32'h11, 0, 1, 32'h22, 0, 5'd1);
        at_neg();
        check("R6 no dispatch in issue cycle", 32'(disp_valid), 0);
        step(); clr_iss();
        at_neg();
        check("R2 dispatch next cycle", 32'(disp_valid), 1);
        step();
        at_neg();
        check("R2 entry gone", 32'(disp_valid), 0);

        // R3 / R11: pending source waits for its tag
        step();
        set_iss(6'h02, 0, 0, 5'd7, 1, 32'h33, 0, 5'd2);
        step(); clr_iss();
        at_neg();
        check("R3 waits on tag", 32'(disp_valid), 0);
        step();
        bc_on(5'd9, 32'hdead);
        step(); bc_off();
        at_neg();
        check("R11 foreign broadcast ignored", 32'(disp_valid), 0);
        expect_disp(6'h02, 32'h77, 32'h33, 5'd2, "R3");
        step();
        bc_on(5'd7, 32'h77);
        step(); bc_off();
        at_neg();
        check("R3 dispatch after broadcast", 32'(disp_valid), 1);
        step();

        // R7: broadcast in the issue cycle
        expect_disp(6'h03, 32'h44, 32'h55, 5'd3, "R7");
        set_iss(6'h03, 1, 32'h44, 0, 0, 0, 5'd3, 5'd3);
        bc_on(5'd3, 32'h55);
        step(); clr_iss(); bc_off();
        at_neg();
        check("R7 ready next cycle", 32'(disp_valid), 1);
        step();

        // R5: bypass on an empty station
        bypass_en = 1'b1;
        expect_disp(6'h04, 32'h66, 32'h88, 5'd4, "R5");
        set_iss(6'h04, 1, 32'h66, 0, 1, 32'h88, 0, 5'd4);
        at_neg();
        check("R5 same-cycle bypass", 32'(disp_valid), 1);
        step(); clr_iss();
        at_neg();
        check("R5 bypassed not stored", 32'(disp_valid), 0);
        step();
        set_iss(6'h05, 0, 0, 5'd14, 1, 32'h99, 0, 5'd5);
        at_neg();
        check("R5 pending operand not bypassed", 32'(disp_valid), 0);
        step(); clr_iss();
        expect_disp(6'h05, 32'haa, 32'h99, 5'd5, "R5");
        bc_on(5'd14, 32'haa);
        step(); bc_off();
        at_neg();
        check("R5 stored entry dispatches", 32'(disp_valid), 1);
        step();
        bypass_en = 1'b0;

        // R8: oldest ready first, after a slot is reused out of order
        set_iss(6'h10, 0, 0, 5'd12, 1, 32'h100, 0, 5'd10); step();
        set_iss(6'h11, 0, 0, 5'd13, 1, 32'h101, 0, 5'd11); step();
        set_iss(6'h12, 0, 0, 5'd13, 1, 32'h102, 0, 5'd12); step();
        clr_iss();
        expect_disp(6'h10, 32'hc0, 32'h100, 5'd10, "R8");
        bc_on(5'd12, 32'hc0);
        step(); bc_off();
        step();
        set_iss(6'h13, 0, 0, 5'd13, 1, 32'h103, 0, 5'd13);
        step(); clr_iss();
        expect_disp(6'h11, 32'hd0, 32'h101, 5'd11, "R8");
        expect_disp(6'h12, 32'hd0, 32'h102, 5'd12, "R8");
        expect_disp(6'h13, 32'hd0, 32'h103, 5'd13, "R8");
        bc_on(5'd13, 32'hd0);
        step(); bc_off();
        for (int k = 0; k < 3; k++) begin
            at_neg();
            check("R8 ready chain", 32'(disp_valid), 1);
            step();
        end
        at_neg();
        check("R8 drained", 32'(disp_valid), 0);

        // R9: strict in-order blocks a younger ready entry
        step();
        in_order = 1'b1;
        set_iss(6'h20, 0, 0, 5'd20, 1, 32'h200, 0, 5'd20); step();
        set_iss(6'h21, 1, 32'h211, 0, 1, 32'h201, 0, 5'd21); step();
        clr_iss();
        at_neg();
        check("R9 younger ready waits", 32'(disp_valid), 0);
        step();
        at_neg();
        check("R9 still waiting", 32'(disp_valid), 0);
        expect_disp(6'h20, 32'he0, 32'h200, 5'd20, "R9");
        expect_disp(6'h21, 32'h211, 32'h201, 5'd21, "R9");
        step();
        bc_on(5'd20, 32'he0);
        step(); bc_off();
        at_neg();
        check("R9 oldest goes", 32'(disp_valid), 1);
        step();
        at_neg();
        check("R9 younger follows", 32'(disp_valid), 1);
        step();
        in_order = 1'b0;

        // R10 / R12: fill, reject, drain one per cycle
        for (int k = 0; k < 4; k++) begin
            set_iss(6'(6'h30 + k), 0, 0, 5'd25, 1, 32'(32'h300 + k), 0, 5'(k));
            step();
        end
        clr_iss();
        at_neg();
        check("R10 iss_ready low when full", 32'(iss_ready), 0);
        step();
        set_iss(6'h3f, 1, 32'h3ff, 0, 1, 32'h3fe, 0, 5'd31);
        step(); clr_iss();
        for (int k = 0; k < 4; k++)
            expect_disp(6'(6'h30 + k), 32'hf0, 32'(32'h300 + k), 5'(k), "R12");
        bc_on(5'd25, 32'hf0);
        step(); bc_off();
        for (int k = 0; k < 4; k++) begin
            at_neg();
            check("R12 one per cycle", 32'(disp_valid), 1);
            step();
        end
        at_neg();
        check("R10 rejected issue not stored", 32'(disp_valid), 0);
        check("R10 iss_ready back", 32'(iss_ready), 1);

        step(); step();
        check("R2 scoreboard empty", 32'(q.size()), 0);
        summary();
    end

endmodule